// File: doc/BRIEF.md
# Per-Channel DMA Completion Interrupt Router

This block gathers transmit-done and receive-done pulses from a set of DMA channels and turns them into interrupt requests. Every pulse sets a sticky status bit for its channel and direction. The bit stays set until software clears it by writing a one. Each channel has its own transmit enable and its own receive enable. The per-channel transmit and receive interrupt lines are each the AND of a status bit and its enable.

A single mode input sets how completion events reach the shared interrupt line:
- With `mode_sel` low, any enabled pending completion also raises the common interrupt and the normal-summary bit.
- With `mode_sel` high, completions reach only the per-channel lines. The common line and the normal summary stay quiet.

A small register port holds the enables and the write-one-to-clear status words. It also holds a two-bit direction mask. The mask selects which directions feed the summarized status that software reads back.

Top module: `dma_irq_router`

## Requirements
- R1: A one-cycle pulse on `tx_done[i]` or `rx_done[i]` sets the matching status bit. The bit is visible on `tx_irq[i]`/`rx_irq[i]` (when enabled) and in the status read from the next cycle onward. It stays set until cleared by software.
- R2: Writing the transmit status word (address 2) or the receive status word (address 3) clears exactly the bits written as one. Bits written as zero keep their value.
- R3: When a completion pulse and a clearing write hit the same status bit in the same cycle, the bit remains set.
- R4: `tx_irq[i]` equals transmit status bit i AND transmit enable bit i. `rx_irq[i]` equals receive status bit i AND receive enable bit i. The transmit enables (address 0, bit i = channel i) and the receive enables (address 1) are written and act independently.
- R5: With `mode_sel` = 0, `common_irq` is high whenever any bit of `tx_irq` or `rx_irq` is high. It is low otherwise.
- R6: With `mode_sel` = 1, `common_irq` stays low regardless of pending completions. The per-channel lines behave as in R4.
- R7: The summary word (address 5) has the following fields:
  - bit 0: the normal summary. It is 1 only when `mode_sel` = 0 and at least one channel has a direction-masked pending interrupt.
  - bit 1: the abnormal summary, which always reads 0.
- R8: The direction mask (address 4) uses bit 0 to include transmit and bit 1 to include receive. Summary bits [NCH+1:2] give, per channel, the OR of the enabled pending interrupts in the included directions.
- R9: After reset, all of the following hold:
  - enables are 0;
  - status is 0;
  - the direction mask is 3 (both directions);
  - all interrupt outputs are low.
- R10: Reads return zero in every bit above the defined fields, and unassigned addresses read as zero. An enable write keeps only bits [NCH-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0: completions also reach the common line; 1: per-channel only |
| tx_done | input | NCH | Transmit-complete pulses, one per channel |
| rx_done | input | NCH | Receive-complete pulses, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tx_irq | output | NCH | Per-channel transmit interrupt lines |
| rx_irq | output | NCH | Per-channel receive interrupt lines |
| common_irq | output | 1 | Common interrupt line |

## Verification
A completion pulse and a software write-one-to-clear can land on the same status bit in one clock. The bench provokes this by driving `tx_done[0]` in the same cycle as a status write that clears bits 0 and 1. It then reads the status word back through the register port. It expects bit 0 still set and bit 1 cleared. A second case repeats this on the receive word while the receive interrupt is enabled, and checks that `rx_irq` never drops.

// File: rtl/dma_irq_pkg.sv
// Shared register addresses and widths for the DMA interrupt router.
package dma_irq_pkg;
    localparam int REG_AW = 3;
    localparam int DATA_W = 32;

    typedef enum logic [REG_AW-1:0] {
        A_TX_EN  = 3'd0,
        A_RX_EN  = 3'd1,
        A_TX_ST  = 3'd2,
        A_RX_ST  = 3'd3,
        A_DIR    = 3'd4,
        A_SUMM   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/dma_irq_stat_bank.sv
// Sticky status bank: one bit per channel, set by an event pulse and
// cleared by a write-one-to-clear vector. Assumes clr_i is already decoded.
// A set in the same cycle as a clear takes priority.
module dma_irq_stat_bank #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] evt_i,
    input  logic [NCH-1:0] clr_i,
    output logic [NCH-1:0] stat_o
);
    logic [NCH-1:0] stat_q;

    // Update status: clear requested bits, then OR in new events (event wins).
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | evt_i;
    end

    assign stat_o = stat_q;

    // R1 R3
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R2
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((~stat_q & $past(stat_q)) == '0));
endmodule

// File: rtl/dma_irq_cfg.sv
// Register write decode: holds the per-channel enables and the direction
// mask, and turns writes to the status addresses into clear vectors.
// Assumes NCH < DATA_W.
module dma_irq_cfg
    import dma_irq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [NCH-1:0]    tx_en_o,
    output logic [NCH-1:0]    rx_en_o,
    output logic [1:0]        dir_o,
    output logic [NCH-1:0]    tx_clr_o,
    output logic [NCH-1:0]    rx_clr_o
);
    logic [NCH-1:0] tx_en_q, rx_en_q;
    logic [1:0]     dir_q;
    logic           unused_wr_hi;

    assign unused_wr_hi = ^wr_data[DATA_W-1:NCH];

    // Hold the enable words and the direction mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= '0;
            rx_en_q <= '0;
            dir_q   <= 2'b11;
        end else if (wr_en) begin
            if (wr_addr == A_TX_EN) tx_en_q <= wr_data[NCH-1:0];
            if (wr_addr == A_RX_EN) rx_en_q <= wr_data[NCH-1:0];
            if (wr_addr == A_DIR)   dir_q   <= wr_data[1:0];
        end
    end

    // Decode write-one-to-clear strobes for the two status words.
    always_comb begin
        tx_clr_o = '0;
        rx_clr_o = '0;
        if (wr_en && wr_addr == A_TX_ST) tx_clr_o = wr_data[NCH-1:0];
        if (wr_en && wr_addr == A_RX_ST) rx_clr_o = wr_data[NCH-1:0];
    end

    assign tx_en_o = tx_en_q;
    assign rx_en_o = rx_en_q;
    assign dir_o   = dir_q;

    // R8
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_DIR) |=> $stable(dir_q));

    // R4
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_TX_EN) |=> $stable(tx_en_q));
endmodule

// File: rtl/dma_irq_merge.sv
// Output merge: gates status with enables to form the per-channel lines,
// builds the direction-masked pending vector, the normal summary, the
// common line, and the register read mux. Purely combinational.
module dma_irq_merge
    import dma_irq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              mode_sel,
    input  logic [NCH-1:0]    tx_st_i,
    input  logic [NCH-1:0]    rx_st_i,
    input  logic [NCH-1:0]    tx_en_i,
    input  logic [NCH-1:0]    rx_en_i,
    input  logic [1:0]        dir_i,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    tx_irq_o,
    output logic [NCH-1:0]    rx_irq_o,
    output logic              common_o
);
    logic [NCH-1:0] pend;
    logic           norm_sum;
    logic           abn_sum;

    // Per-channel lines and direction-masked pending bits.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign tx_irq_o[c] = tx_st_i[c] & tx_en_i[c];
        assign rx_irq_o[c] = rx_st_i[c] & rx_en_i[c];
        assign pend[c]     = (dir_i[0] & tx_irq_o[c]) | (dir_i[1] & rx_irq_o[c]);
    end

    assign abn_sum  = 1'b0;
    assign norm_sum = ~mode_sel & (|pend);
    assign common_o = (~mode_sel & (|tx_irq_o | |rx_irq_o)) | abn_sum;

    // Register read mux; undefined bits and addresses read zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_TX_EN: rd_data[NCH-1:0] = tx_en_i;
            A_RX_EN: rd_data[NCH-1:0] = rx_en_i;
            A_TX_ST: rd_data[NCH-1:0] = tx_st_i;
            A_RX_ST: rd_data[NCH-1:0] = rx_st_i;
            A_DIR:   rd_data[1:0]     = dir_i;
            A_SUMM: begin
                rd_data[0]       = norm_sum;
                rd_data[1]       = abn_sum;
                rd_data[NCH+1:2] = pend;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_irq_router.sv
// Top of the DMA completion interrupt router. Wires two sticky status
// banks (transmit, receive), the register decode and the output merge.
// Assumes completion pulses are synchronous to clk and NCH + 2 <= 32.
module dma_irq_router
    import dma_irq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic [NCH-1:0]    tx_done,
    input  logic [NCH-1:0]    rx_done,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    tx_irq,
    output logic [NCH-1:0]    rx_irq,
    output logic              common_irq
);
    logic [NCH-1:0] tx_en, rx_en, tx_clr, rx_clr, tx_st, rx_st;
    logic [1:0]     dir;

    dma_irq_cfg #(.NCH(NCH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_en_o(tx_en), .rx_en_o(rx_en), .dir_o(dir),
        .tx_clr_o(tx_clr), .rx_clr_o(rx_clr)
    );

    dma_irq_stat_bank #(.NCH(NCH)) u_tx_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(tx_done), .clr_i(tx_clr), .stat_o(tx_st)
    );

    dma_irq_stat_bank #(.NCH(NCH)) u_rx_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(rx_done), .clr_i(rx_clr), .stat_o(rx_st)
    );

    dma_irq_merge #(.NCH(NCH)) u_merge (
        .mode_sel(mode_sel), .tx_st_i(tx_st), .rx_st_i(rx_st),
        .tx_en_i(tx_en), .rx_en_i(rx_en), .dir_i(dir), .rd_addr(rd_addr),
        .rd_data(rd_data), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
        .common_o(common_irq)
    );

    // R5
    common_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && (tx_irq != '0 || rx_irq != '0)) |-> common_irq);

    // R6
    mode1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_sel |-> !common_irq);
endmodule

// File: tb/dma_irq_router_bench.sv
module dma_irq_router_bench;
    localparam int PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0;
    logic [3:0]  tx_done = '0, rx_done = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  tx_irq, rx_irq;
    logic        common_irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    dma_irq_router #(.NCH(NCH)) u_dma_irq_router (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .tx_done(tx_done),
        .rx_done(rx_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .common_irq(common_irq)
    );

    typedef struct packed {
        logic [3:0] txe;
        logic [3:0] rxe;
        logic [3:0] txen;
        logic [3:0] rxen;
        logic [1:0] dir;
        logic       mode;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{4'b0001, 4'b0000, 4'hF,    4'hF,    2'd3, 1'b0},
        '{4'b0000, 4'b1000, 4'hF,    4'hF,    2'd3, 1'b1},
        '{4'b0101, 4'b1010, 4'b0101, 4'b0000, 2'd3, 1'b0},
        '{4'b1111, 4'b1111, 4'b0011, 4'b1100, 2'd1, 1'b0},
        '{4'b1111, 4'b1111, 4'b0011, 4'b1100, 2'd2, 1'b0},
        '{4'b0010, 4'b0100, 4'b0000, 4'b1111, 2'd1, 1'b0},
        '{4'b1001, 4'b0110, 4'hF,    4'hF,    2'd3, 1'b1},
        '{4'b0000, 4'b0000, 4'hF,    4'hF,    2'd3, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one register write; called and returns at a negedge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic [3:0] t, input logic [3:0] r);
        tx_done = t; rx_done = r;
        @(negedge clk);
        tx_done = '0; rx_done = '0;
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        chk("R9 tx_irq", {28'd0, tx_irq}, 0);
        chk("R9 rx_irq", {28'd0, rx_irq}, 0);
        chk("R9 common", {31'd0, common_irq}, 0);
        rd(3'd0, d); chk("R9 tx_en", d, 0);
        rd(3'd1, d); chk("R9 rx_en", d, 0);
        rd(3'd4, d); chk("R9 dir", d, 32'd3);
        rd(3'd5, d); chk("R9 summary", d, 0);

        // Table walk: R4 R5 R6 R7 R8 R1
        for (int i = 0; i < NV; i++) begin
            logic [3:0] et, er, pd;
            logic ec, ns;
            wr(3'd2, 32'hF);
            wr(3'd3, 32'hF);
            wr(3'd0, {28'd0, VECS[i].txen});
            wr(3'd1, {28'd0, VECS[i].rxen});
            wr(3'd4, {30'd0, VECS[i].dir});
            mode_sel = VECS[i].mode;
            pulse(VECS[i].txe, VECS[i].rxe);
            et = VECS[i].txe & VECS[i].txen;
            er = VECS[i].rxe & VECS[i].rxen;
            ec = !VECS[i].mode && ((et | er) != 0);
            pd = (VECS[i].dir[0] ? et : 4'd0) | (VECS[i].dir[1] ? er : 4'd0);
            ns = !VECS[i].mode && (pd != 0);
            #1;
            chk("R4 tx_irq", {28'd0, tx_irq}, {28'd0, et});
            chk("R4 rx_irq", {28'd0, rx_irq}, {28'd0, er});
            chk(VECS[i].mode ? "R6 common" : "R5 common", {31'd0, common_irq}, {31'd0, ec});
            rd(3'd2, d); chk("R1 tx status", d, {28'd0, VECS[i].txe});
            rd(3'd3, d); chk("R1 rx status", d, {28'd0, VECS[i].rxe});
            rd(3'd5, d); chk("R7 R8 summary", d, {26'd0, pd, 1'b0, ns});
        end

        // R1 sticky over several cycles
        wr(3'd2, 32'hF); wr(3'd3, 32'hF);
        wr(3'd0, 32'hF); wr(3'd1, 32'hF); wr(3'd4, 32'd3);
        mode_sel = 1'b0;
        pulse(4'b0100, 4'b0000);
        repeat (5) @(negedge clk);
        chk("R1 sticky tx_irq", {28'd0, tx_irq}, 32'h4);

        // R2 zero bits ignored, one bits cleared
        pulse(4'b0011, 4'b0000);
        wr(3'd2, 32'h0);
        rd(3'd2, d); chk("R2 zero write", d, 32'h7);
        wr(3'd2, 32'h2);
        rd(3'd2, d); chk("R2 partial clear", d, 32'h5);

        // R3 event and clear collide on tx bit 0; bit 1 clears normally
        pulse(4'b0010, 4'b0000);
        tx_done = 4'b0001;
        wr(3'd2, 32'h3);
        tx_done = '0;
        rd(3'd2, d); chk("R3 tx collision", d, 32'h5);

        // R3 on receive word with enabled line
        pulse(4'b0000, 4'b1000);
        rx_done = 4'b1000;
        wr(3'd3, 32'h8);
        rx_done = '0;
        #1;
        chk("R3 rx_irq held", {28'd0, rx_irq}, 32'h8);

        // R6 mode flip with pending interrupts
        mode_sel = 1'b1; #1;
        chk("R6 common quiet", {31'd0, common_irq}, 0);
        chk("R6 lines kept", {28'd0, tx_irq}, 32'h5);
        rd(3'd5, d); chk("R7 summary mode1", d[0], 0);
        mode_sel = 1'b0; #1;
        chk("R5 common back", {31'd0, common_irq}, 1);

        // R4 independent enables: disable tx only
        wr(3'd0, 32'h0); #1;
        chk("R4 tx masked", {28'd0, tx_irq}, 0);
        chk("R4 rx kept", {28'd0, rx_irq}, 32'h8);

        // R10 width of enables and unused addresses
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d); chk("R10 en width", d, 32'hF);
        rd(3'd6, d); chk("R10 unused addr", d, 0);
        rd(3'd5, d); chk("R7 abnormal zero", d[1], 0);

        // R9 reset mid-run
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; #1;
        chk("R9 reset clears", {24'd0, tx_irq, rx_irq}, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule